// File: doc/BRIEF.md
# Processor Exception Entry and Return Sequencer

This block sits beside a 32-bit core's fetch logic and owns the program status word. Each cycle it looks at the exception requests the core raises: undefined instruction, software trap, instruction-fetch abort, data-access abort, normal interrupt and fast interrupt. A synchronous reset acts as the highest-ranked exception. It takes at most one request per cycle. In a single clock edge it makes the whole entry. The old status word and the supplied return address go into the saved-status and link slots of the target mode. The status word is rewritten with the new mode, the 32-bit instruction state and the mask bits. The PC is redirected to the vector address.

A return request does the reverse. It reloads the status word from the saved slot of the current mode and redirects the PC to that mode's link value. A plain write port lets the core replace the status word, for example when handler code changes the masks or the mode. The redirect strobe and the new PC reach the fetch unit one cycle after the request is sampled.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `psr_o` = 0x000000D3, `pc_o` = the selected vector base and `redirect_o` = 1, whatever else is requested. 0x000000D3 is mode 10011 in bits 4:0, F (bit 6) = 1, I (bit 7) = 1, T (bit 5) = 0 and J (bit 24) = 0.
- R2: The vector address is the base ORed with the offset. The base is 0x00000000 when `hivec_i` = 0 and 0xFFFF0000 when it is 1. The offsets are: undefined 0x04, software trap 0x08, fetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C.
- R3: When several requests arrive together, only one is taken. The order from highest is reset, data abort, fast interrupt, interrupt, fetch abort, undefined, software trap.
- R4: The entered mode (bits 4:0) is 10011 for the software trap, 11011 for undefined, 10111 for both aborts, 10010 for interrupt and 10001 for fast interrupt.
- R5: On entry, bit 5 and bit 24 clear and bit 7 sets. Bit 6 sets for a fast interrupt and is kept for every other exception. All remaining bits are kept.
- R6: `irq_i` is ignored while bit 7 is 1 and `fiq_i` is ignored while bit 6 is 1. A masked request neither redirects nor changes the status word, and the next enabled request by rank is taken instead.
- R7: An entry saves the old status word and `link_i` in the target mode's slots. A later return from that mode gives them back on `psr_o` and `pc_o`.
- R8: `eret_i` in a mode that has saved slots (10001, 10010, 10011, 10111, 11011) restores `psr_o` and `pc_o` and pulses `redirect_o`. In any other mode (10000, 11111 and so on) it is ignored: no redirect and no status change.
- R9: An exception beats a return in the same cycle, and a return beats a status write.
- R10: `psr_we_i` loads the whole of `psr_wd_i` into `psr_o` one cycle later, without a redirect.
- R11: `redirect_o` is high for exactly the one cycle after an entry or a taken return and low otherwise.
- R12: Each exception mode has its own slots. A nested entry into a second mode keeps the first mode's saved state intact for its own return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, taken as the reset exception |
| hivec_i | input | 1 | Vector base select: 0 low, 1 high |
| und_i | input | 1 | Undefined-instruction request |
| swi_i | input | 1 | Software trap request |
| pabt_i | input | 1 | Instruction-fetch abort request |
| dabt_i | input | 1 | Data-access abort request |
| irq_i | input | 1 | Interrupt request |
| fiq_i | input | 1 | Fast interrupt request |
| eret_i | input | 1 | Return-from-exception request |
| link_i | input | DW | Return address saved on entry |
| psr_we_i | input | 1 | Status word write enable |
| psr_wd_i | input | DW | Status word write data |
| pc_o | output | DW | Redirect target |
| psr_o | output | DW | Current status word |
| redirect_o | output | 1 | PC redirect strobe |

## Verification
The bench builds the block with its defaults: a 32-bit word and the two standard vector bases. With this small configuration it can sweep all 64 combinations of the six request lines, for each of the four interrupt-mask settings and both vector bases. That sweep covers every priority, masking and vector case, and after each entry a return checks the saved slots. Directed sequences nest entries across modes, overlap a return with an exception or a status write, and apply reset with requests pending.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef logic [4:0] mode_t;

  localparam mode_t M_USR = 5'b10000;
  localparam mode_t M_FIQ = 5'b10001;
  localparam mode_t M_IRQ = 5'b10010;
  localparam mode_t M_SVC = 5'b10011;
  localparam mode_t M_ABT = 5'b10111;
  localparam mode_t M_UND = 5'b11011;
  localparam mode_t M_SYS = 5'b11111;

  // code value times four is the vector offset
  typedef enum logic [2:0] {
    X_RST  = 3'd0,
    X_UND  = 3'd1,
    X_SWI  = 3'd2,
    X_PABT = 3'd3,
    X_DABT = 3'd4,
    X_RSVD = 3'd5,
    X_IRQ  = 3'd6,
    X_FIQ  = 3'd7
  } exc_t;

  localparam int BIT_T = 5;
  localparam int BIT_F = 6;
  localparam int BIT_I = 7;
  localparam int BIT_J = 24;

  localparam int NBANK  = 5;
  localparam int BANK_W = $clog2(NBANK);
  localparam int NSRC   = 6;

  function automatic mode_t mode_of(exc_t e);
    case (e)
      X_UND:        return M_UND;
      X_PABT,
      X_DABT:       return M_ABT;
      X_IRQ:        return M_IRQ;
      X_FIQ:        return M_FIQ;
      default:      return M_SVC;
    endcase
  endfunction

  function automatic logic has_bank(mode_t m);
    return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
           (m == M_ABT) || (m == M_UND);
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(mode_t m);
    case (m)
      M_FIQ:   return BANK_W'(0);
      M_IRQ:   return BANK_W'(1);
      M_SVC:   return BANK_W'(2);
      M_ABT:   return BANK_W'(3);
      default: return BANK_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int NREQ = 6,
  localparam int IW = $clog2(NREQ)
) (
  input  logic [NREQ-1:0] req_i,
  output logic            hit_o,
  output logic [IW-1:0]   idx_o
);
  // index 0 carries the highest rank
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = NREQ - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        hit_o = 1'b1;
        idx_o = IW'(k);
      end
    end
  end
endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 5,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wpsr_i,
  input  logic [DW-1:0] wlink_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rpsr_o,
  output logic [DW-1:0] rlink_o
);
  logic [DW-1:0] psr_mem  [DEPTH];
  logic [DW-1:0] link_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      psr_mem[waddr_i]  <= wpsr_i;
      link_mem[waddr_i] <= wlink_i;
    end
  end

  assign rpsr_o  = psr_mem[raddr_i];
  assign rlink_o = link_mem[raddr_i];
endmodule

// File: rtl/exc_entry_psr.sv
module exc_entry_psr
  import exc_pkg::*;
#(
  parameter int          DW        = 32,
  parameter logic [DW-1:0] LOW_BASE  = '0,
  parameter logic [DW-1:0] HIGH_BASE = DW'(32'hFFFF0000)
) (
  input  logic [DW-1:0] old_psr_i,
  input  exc_t          code_i,
  input  logic          hivec_i,
  output logic [DW-1:0] new_psr_o,
  output logic [DW-1:0] vec_o
);
  always_comb begin
    new_psr_o        = old_psr_i;
    new_psr_o[4:0]   = mode_of(code_i);
    new_psr_o[BIT_T] = 1'b0;
    new_psr_o[BIT_J] = 1'b0;
    new_psr_o[BIT_I] = 1'b1;
    if (code_i == X_FIQ) new_psr_o[BIT_F] = 1'b1;
  end

  assign vec_o = (hivec_i ? HIGH_BASE : LOW_BASE) | DW'({code_i, 2'b00});
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int            DW        = 32,
  parameter logic [DW-1:0] LOW_BASE  = '0,
  parameter logic [DW-1:0] HIGH_BASE = DW'(32'hFFFF0000)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hivec_i,
  input  logic          und_i,
  input  logic          swi_i,
  input  logic          pabt_i,
  input  logic          dabt_i,
  input  logic          irq_i,
  input  logic          fiq_i,
  input  logic          eret_i,
  input  logic [DW-1:0] link_i,
  input  logic          psr_we_i,
  input  logic [DW-1:0] psr_wd_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] psr_o,
  output logic          redirect_o
);
  localparam int IW = $clog2(NSRC);
  localparam logic [DW-1:0] RESET_PSR =
    DW'(M_SVC) | (DW'(1) << BIT_I) | (DW'(1) << BIT_F);
  localparam exc_t PRIO [NSRC] = '{X_DABT, X_FIQ, X_IRQ, X_PABT, X_UND, X_SWI};

  logic [DW-1:0] psr_q, pc_q;
  logic          redir_q;

  logic [NSRC-1:0] ranked;
  logic            hit;
  logic [IW-1:0]   hit_idx;
  exc_t            win;
  logic [DW-1:0]   entry_psr, entry_vec;
  logic [DW-1:0]   saved_psr, saved_link;
  logic            ret_ok;
  logic [DW-1:0]   base_w;

  // requests in rank order, masks applied from the live status word
  assign ranked = {swi_i, und_i, pabt_i,
                   irq_i & ~psr_q[BIT_I],
                   fiq_i & ~psr_q[BIT_F],
                   dabt_i};

  exc_arbiter #(.NREQ(NSRC)) u_arb (
    .req_i (ranked),
    .hit_o (hit),
    .idx_o (hit_idx)
  );

  assign win = hit ? PRIO[hit_idx] : X_RST;

  exc_entry_psr #(.DW(DW), .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE)) u_psr (
    .old_psr_i (psr_q),
    .code_i    (win),
    .hivec_i   (hivec_i),
    .new_psr_o (entry_psr),
    .vec_o     (entry_vec)
  );

  exc_bank #(.DW(DW), .DEPTH(NBANK)) u_bank (
    .clk     (clk),
    .we_i    (hit && !rst),
    .waddr_i (bank_of(mode_of(win))),
    .wpsr_i  (psr_q),
    .wlink_i (link_i),
    .raddr_i (bank_of(psr_q[4:0])),
    .rpsr_o  (saved_psr),
    .rlink_o (saved_link)
  );

  assign ret_ok = eret_i && has_bank(psr_q[4:0]);
  assign base_w = hivec_i ? HIGH_BASE : LOW_BASE;

  always_ff @(posedge clk) begin
    if (rst) begin
      psr_q   <= RESET_PSR;
      pc_q    <= base_w;
      redir_q <= 1'b1;
    end else if (hit) begin
      psr_q   <= entry_psr;
      pc_q    <= entry_vec;
      redir_q <= 1'b1;
    end else if (ret_ok) begin
      psr_q   <= saved_psr;
      pc_q    <= saved_link;
      redir_q <= 1'b1;
    end else begin
      if (psr_we_i) psr_q <= psr_wd_i;
      redir_q <= 1'b0;
    end
  end

  assign pc_o       = pc_q;
  assign psr_o      = psr_q;
  assign redirect_o = redir_q;
endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk #(
  parameter int            DW        = 32,
  parameter logic [DW-1:0] LOW_BASE  = '0,
  parameter logic [DW-1:0] HIGH_BASE = DW'(32'hFFFF0000)
) (
  input logic          clk,
  input logic          rst,
  input logic          hivec_i,
  input logic          und_i,
  input logic          swi_i,
  input logic          pabt_i,
  input logic          dabt_i,
  input logic          irq_i,
  input logic          fiq_i,
  input logic          eret_i,
  input logic          psr_we_i,
  input logic [DW-1:0] pc_o,
  input logic [DW-1:0] psr_o,
  input logic          redirect_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (psr_o == DW'(32'hD3)) && redirect_o &&
            (pc_o == ($past(hivec_i) ? HIGH_BASE : LOW_BASE)));

  a_r3_dabt_first: assert property (@(posedge clk) disable iff (rst)
    dabt_i |=> redirect_o && (psr_o[4:0] == 5'b10111) && (pc_o[4:0] == 5'h10));

  a_r5_fiq_entry: assert property (@(posedge clk) disable iff (rst)
    (fiq_i && !psr_o[6] && !dabt_i) |=>
      psr_o[6] && psr_o[7] && !psr_o[5] && !psr_o[24] && (psr_o[4:0] == 5'b10001));

  a_r6_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (irq_i && psr_o[7] && !dabt_i && !fiq_i && !pabt_i && !und_i && !swi_i && !eret_i)
      |=> !redirect_o);

  a_r8_user_return_ignored: assert property (@(posedge clk) disable iff (rst)
    (eret_i && (psr_o[4:0] == 5'b10000) && !psr_we_i &&
     !dabt_i && !fiq_i && !irq_i && !pabt_i && !und_i && !swi_i)
      |=> !redirect_o && $stable(psr_o));

  a_r11_redirect_cause: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> $past(rst || und_i || swi_i || pabt_i || dabt_i ||
                         irq_i || fiq_i || eret_i));
endmodule

bind exc_entry_unit exc_entry_unit_chk #(
  .DW(DW), .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hivec_i    (hivec_i),
  .und_i      (und_i),
  .swi_i      (swi_i),
  .pabt_i     (pabt_i),
  .dabt_i     (dabt_i),
  .irq_i      (irq_i),
  .fiq_i      (fiq_i),
  .eret_i     (eret_i),
  .psr_we_i   (psr_we_i),
  .pc_o       (pc_o),
  .psr_o      (psr_o),
  .redirect_o (redirect_o)
);

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
  localparam int CLK_P = 10;
  localparam logic [31:0] HI = 32'hFFFF0000;

  logic clk = 1'b0;
  logic rst, hivec, und, swi, pabt, dabt, irq, fiq, eret, we;
  logic [31:0] link, wd, pc, psr;
  logic redirect;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  exc_entry_unit i_exc_entry_unit (
    .clk(clk), .rst(rst), .hivec_i(hivec), .und_i(und), .swi_i(swi),
    .pabt_i(pabt), .dabt_i(dabt), .irq_i(irq), .fiq_i(fiq), .eret_i(eret),
    .link_i(link), .psr_we_i(we), .psr_wd_i(wd), .pc_o(pc), .psr_o(psr),
    .redirect_o(redirect)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_win(logic [5:0] r, logic mi, logic mf);
    // r = {swi, und, pabt, irq, fiq, dabt}
    if (r[0]) return 4;
    if (r[1] && !mf) return 7;
    if (r[2] && !mi) return 6;
    if (r[3]) return 3;
    if (r[4]) return 1;
    if (r[5]) return 2;
    return -1;
  endfunction

  function automatic logic [4:0] exp_mode(int c);
    case (c)
      1: return 5'b11011;
      3, 4: return 5'b10111;
      6: return 5'b10010;
      7: return 5'b10001;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] exp_psr(logic [31:0] o, int c);
    logic [31:0] n = o;
    n[4:0] = exp_mode(c);
    n[5] = 1'b0;
    n[24] = 1'b0;
    n[7] = 1'b1;
    if (c == 7) n[6] = 1'b1;
    return n;
  endfunction

  task automatic clear_in();
    und = 0; swi = 0; pabt = 0; dabt = 0; irq = 0; fiq = 0;
    eret = 0; we = 0;
  endtask

  task automatic write_psr(logic [31:0] v);
    we = 1; wd = v;
    step();
    we = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] upsr, irq_psr;
    rst = 1; hivec = 0; link = 0; wd = 0;
    clear_in();
    dabt = 1; irq = 1;
    @(negedge clk);
    chk("R1 reset psr", psr, 32'hD3);
    chk("R1 reset pc", pc, 32'h0);
    chk("R1 reset redirect", {31'd0, redirect}, 32'd1);
    clear_in();
    rst = 0;
    step();
    chk("R11 redirect drops", {31'd0, redirect}, 32'd0);

    // R10 write, R8 ignored return in user and system modes
    write_psr(32'h40000010);
    chk("R10 write psr", psr, 32'h40000010);
    chk("R10 no redirect", {31'd0, redirect}, 32'd0);
    eret = 1; step(); eret = 0;
    chk("R8 user return redirect", {31'd0, redirect}, 32'd0);
    chk("R8 user return psr", psr, 32'h40000010);
    write_psr(32'h0000001F);
    eret = 1; step(); eret = 0;
    chk("R8 system return redirect", {31'd0, redirect}, 32'd0);
    chk("R8 system return psr", psr, 32'h0000001F);

    // sweep: R2 R3 R4 R5 R6 R7 R11
    for (int h = 0; h < 2; h++) begin
      for (int mk = 0; mk < 4; mk++) begin
        for (int r = 0; r < 64; r++) begin
          logic [31:0] bpsr, lk, bs;
          int w;
          bpsr = 32'hA1000030 | (32'(mk & 1) << 7) | (32'(mk >> 1) << 6);
          lk = 32'h10000000 + 32'((h * 256 + mk * 64 + r) * 4);
          bs = (h != 0) ? HI : 32'h0;
          hivec = h[0];
          write_psr(bpsr);
          chk("R10 sweep write", psr, bpsr);
          {swi, und, pabt, irq, fiq, dabt} = 6'(r);
          link = lk;
          step();
          clear_in();
          w = exp_win(6'(r), mk[0], mk[1]);
          if (w >= 0) begin
            chk("R11 entry redirect", {31'd0, redirect}, 32'd1);
            chk("R2 vector", pc, bs | 32'(w * 4));
            chk("R3 R4 R5 entry psr", psr, exp_psr(bpsr, w));
            eret = 1; step(); eret = 0;
            chk("R7 restored psr", psr, bpsr);
            chk("R7 restored pc", pc, lk);
            chk("R8 return redirect", {31'd0, redirect}, 32'd1);
            step();
            chk("R11 single pulse", {31'd0, redirect}, 32'd0);
          end else begin
            chk("R6 masked no redirect", {31'd0, redirect}, 32'd0);
            chk("R6 masked psr", psr, bpsr);
          end
        end
      end
    end

    // R12 nesting, R9 overlaps
    hivec = 0;
    upsr = 32'h20000010;
    write_psr(upsr);
    irq = 1; link = 32'h00001000; step(); clear_in();
    irq_psr = exp_psr(upsr, 6);
    chk("R4 irq mode", psr, irq_psr);
    pabt = 1; eret = 1; link = 32'h00002000; step(); clear_in();
    chk("R9 exception beats return", psr, exp_psr(irq_psr, 3));
    chk("R9 exception vector", pc, 32'h0C);
    fiq = 1; link = 32'h00003000; step(); clear_in();
    chk("R12 nested fiq psr", psr, exp_psr(exp_psr(irq_psr, 3), 7));
    eret = 1; step(); clear_in();
    chk("R12 back to abort psr", psr, exp_psr(irq_psr, 3));
    chk("R12 back to abort pc", pc, 32'h00003000);
    eret = 1; step(); clear_in();
    chk("R12 back to irq psr", psr, irq_psr);
    chk("R12 back to irq pc", pc, 32'h00002000);
    eret = 1; we = 1; wd = 32'h0000001F; step(); clear_in();
    chk("R9 return beats write psr", psr, upsr);
    chk("R9 return beats write pc", pc, 32'h00001000);

    // R1 with high vectors
    hivec = 1; rst = 1; swi = 1; step(); clear_in(); rst = 0;
    chk("R1 high reset pc", pc, HI);
    chk("R1 high reset psr", psr, 32'hD3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule